// File: doc/BRIEF.md
# Quad-Precision Round and Pack Unit

This unit finishes a binary128 result. It takes an unpacked value and returns one correctly rounded 128-bit word with three exception flags. The unpacked value has a sign, a 32-bit two's-complement exponent that is one below the true exponent, a 113-bit significand and a 64-bit guard word. The significand is split into a 49-bit upper part, whose top bit is the integer bit, and a 64-bit lower part. The guard word holds the round bit and the sticky bits of the value. Each request also carries a rounding mode and a flag that chooses whether tininess is judged before or after rounding.

The unit detects overflow and returns either infinity or the largest finite magnitude. A value below the normal range is shifted right into the subnormal range. Every bit that leaves the shifter is folded into the bottom of the guard word. The final word is formed by adding the sign, the exponent and the significand at their field offsets. A 1 in the integer bit, or a carry from rounding, therefore lands in the exponent field.

Requests use a valid/ready stream and so do results. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears registered on the next cycle. `in_ready` is high when the output register is empty or when the consumer is taking its contents in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken.

Top module: `fpq_round_pack`

## Requirements
- R1: With mode code 00 (nearest-even), the significand increments when bit 63 of the guard word is 1. When the guard word is exactly 0x8000_0000_0000_0000, the result's least significant bit is cleared after the increment.
- R2: Mode code 01 (toward zero) never increments. Mode code 11 (upward) increments only for a positive sign with a nonzero guard word. Mode code 10 (downward) increments only for a negative sign with a nonzero guard word.
- R3: Overflow is detected when the exponent is above 0x7FFD as a signed value. It is also detected when the exponent is 0x7FFD, the significand is all ones and an increment is pending. Overflow sets both the overflow flag (out_ovf) and the inexact flag (out_inx).
- R4: On overflow, the result is the largest finite value: exponent field 0x7FFE with every fraction bit set. This applies for toward-zero, for upward with a negative sign and for downward with a positive sign. In every other case the result is infinity: exponent field 0x7FFF with a zero fraction. The sign is kept in bit 127.
- R5: A negative exponent shifts the significand and guard word right by its magnitude, and shifted-out bits are ORed into guard bit 0. The exponent then becomes 0 and the increment is decided again from the new guard word. Shifts of 177 or more leave only the sticky bit.
- R6: When the exponent is negative, the value is tiny if any of these holds: the before-rounding select is set, the exponent is below -1, no increment was pending, or the significand is not all ones. The underflow flag (out_unf) is set when the value is tiny and the shifted guard word is nonzero.
- R7: out_inx is set whenever the final guard word is nonzero.
- R8: When there is no increment and the significand is zero, the exponent field is forced to 0.
- R9: The output word is the sum of the sign at bit 127, the exponent at bit 112 and the 113-bit significand. The integer bit, or a rounding carry, therefore adds into the exponent field.
- R10: A request taken at one clock edge shows up with out_valid high after the next edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output word and flags hold steady.
- R11: During and after reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 32 | Two's-complement exponent, one below the true exponent |
| in_sig_hi | input | 49 | Upper significand bits, with the integer bit at the top |
| in_sig_lo | input | 64 | Lower significand bits |
| in_extra | input | 64 | Guard word holding the round and sticky bits |
| in_rmode | input | 2 | 00 nearest-even, 01 toward zero, 10 downward, 11 upward |
| in_tiny_before | input | 1 | 1 judges tininess before rounding, 0 after rounding |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 128 | Packed binary128 result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
A table of values drives the rounding modes through guard words that separate the cases. An exact tie with an even and with an odd LSB tells tie-to-even apart from plain round-half-up. A guard word just above half checks the increment on bit 63. A guard word of 1 under both signs separates the upward and downward directed modes.

At the top of the range, exponent 0x7FFD with an all-ones significand is tried with and without a pending increment, which pins down the overflow boundary. The overflow cases cover every sign and mode pairing that chooses between infinity and the largest finite value.

Below the range, exponent -1 with an all-ones significand and a half guard word is run under both tininess selects. The result is the same both times, so only the underflow flag tells the two rules apart. A very large shift, the most negative exponent, a zero significand and an all-ones carry into the exponent cover the sticky path, the zero case and the packing carry. Back-pressure is tested directly by holding out_ready low while a second request waits.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpq_inc_decide.sv
module fpq_inc_decide
  import fpq_pkg::*;
#(
  parameter int unsigned XTR_W = 64
) (
  input  logic             sign,
  input  logic [XTR_W-1:0] guard,
  input  rmode_e           mode,
  output logic             inc
);
  always_comb begin
    unique case (mode)
      RM_NEAR: inc = guard[XTR_W-1];
      RM_ZERO: inc = 1'b0;
      RM_DOWN: inc = sign && (|guard);
      default: inc = !sign && (|guard);
    endcase
  end
endmodule

// File: rtl/fpq_sticky_rshift.sv
module fpq_sticky_rshift #(
  parameter int unsigned W     = 177,
  parameter int unsigned AMT_W = 32
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  localparam int unsigned SH_W = $clog2(W + 1);
  localparam logic [AMT_W-1:0] LIMIT = AMT_W'(W);

  logic            too_far;
  logic [SH_W-1:0] sh;
  logic [W-1:0]    moved;
  logic            lost;

  always_comb begin
    too_far = (amt >= LIMIT);
    sh      = too_far ? '0 : amt[SH_W-1:0];
    moved   = din >> sh;
    lost    = ((moved << sh) != din);
    if (too_far) dout = {{(W-1){1'b0}}, |din};
    else         dout = {moved[W-1:1], moved[0] | lost};
  end
endmodule

// File: rtl/fpq_round_core.sv
module fpq_round_core
  import fpq_pkg::*;
#(
  parameter int unsigned SIG_W    = 113,
  parameter int unsigned XTR_W    = 64,
  parameter int unsigned EXP_IN_W = 32,
  parameter int unsigned EXP_F_W  = 15
) (
  input  logic                       sign,
  input  logic [EXP_IN_W-1:0]        exp_in,
  input  logic [SIG_W-1:0]           sig,
  input  logic [XTR_W-1:0]           extra,
  input  rmode_e                     mode,
  input  logic                       tiny_before,
  output logic [EXP_F_W+SIG_W-1:0]   word,
  output logic                       ovf,
  output logic                       unf,
  output logic                       inx
);
  localparam int unsigned WORD_W = EXP_F_W + SIG_W;
  localparam int unsigned CAT_W  = SIG_W + XTR_W;
  localparam logic [EXP_IN_W-1:0] EXP_EDGE = EXP_IN_W'((1 << EXP_F_W) - 3);
  localparam logic [EXP_F_W-1:0]  EXP_INF  = '1;
  localparam logic [EXP_F_W-1:0]  EXP_MAXF = EXP_F_W'((1 << EXP_F_W) - 2);
  localparam logic [XTR_W-1:0]    HALF     = {1'b1, {(XTR_W-1){1'b0}}};

  logic                 inc0, inc1, all1, neg, above, ovf_c, tiny, pick_max;
  logic [CAT_W-1:0]     shifted;
  logic [SIG_W-1:0]     sig_f;
  logic [XTR_W-1:0]     ext_f;
  logic                 inc_f, tie;
  logic [SIG_W:0]       sig_r;
  logic [EXP_F_W-1:0]   exp_p;
  logic [WORD_W-1:0]    packed_w;

  fpq_inc_decide #(.XTR_W(XTR_W)) u_dec_pre (
    .sign(sign), .guard(extra), .mode(mode), .inc(inc0)
  );

  fpq_sticky_rshift #(.W(CAT_W), .AMT_W(EXP_IN_W)) u_denorm (
    .din({sig, extra}), .amt(-exp_in), .dout(shifted)
  );

  fpq_inc_decide #(.XTR_W(XTR_W)) u_dec_post (
    .sign(sign), .guard(shifted[XTR_W-1:0]), .mode(mode), .inc(inc1)
  );

  always_comb begin
    all1     = &sig;
    neg      = exp_in[EXP_IN_W-1];
    above    = (exp_in >= EXP_EDGE) && !neg;
    ovf_c    = above && ((exp_in != EXP_EDGE) || (all1 && inc0));
    tiny     = tiny_before || ($signed(exp_in) < -1) || !inc0 || !all1;
    pick_max = (mode == RM_ZERO) || (sign && mode == RM_UP) || (!sign && mode == RM_DOWN);

    sig_f = neg ? shifted[CAT_W-1:XTR_W] : sig;
    ext_f = neg ? shifted[XTR_W-1:0]     : extra;
    inc_f = neg ? inc1 : inc0;
    tie   = (ext_f == HALF);

    if (inc_f) begin
      sig_r = {1'b0, sig_f} + (SIG_W+1)'(1);
      if (mode == RM_NEAR && tie) sig_r[0] = 1'b0;
    end else begin
      sig_r = {1'b0, sig_f};
    end

    if (neg || (!inc_f && sig_f == '0)) exp_p = '0;
    else                                exp_p = exp_in[EXP_F_W-1:0];

    packed_w = {sign, {(WORD_W-1){1'b0}}}
             + ({{SIG_W{1'b0}}, exp_p} << (SIG_W-1))
             + {{(EXP_F_W-1){1'b0}}, sig_r};

    if (ovf_c) begin
      word = pick_max ? {sign, EXP_MAXF, {(SIG_W-1){1'b1}}}
                      : {sign, EXP_INF,  {(SIG_W-1){1'b0}}};
      ovf  = 1'b1;
      unf  = 1'b0;
      inx  = 1'b1;
    end else begin
      word = packed_w;
      ovf  = 1'b0;
      unf  = neg && tiny && (ext_f != '0);
      inx  = (ext_f != '0);
    end
  end
endmodule

// File: rtl/fpq_round_pack.sv
module fpq_round_pack
  import fpq_pkg::*;
#(
  parameter int unsigned SIG_HI_W = 49,
  parameter int unsigned SIG_LO_W = 64,
  parameter int unsigned XTR_W    = 64,
  parameter int unsigned EXP_IN_W = 32,
  parameter int unsigned EXP_F_W  = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sign,
  input  logic [EXP_IN_W-1:0]       in_exp,
  input  logic [SIG_HI_W-1:0]       in_sig_hi,
  input  logic [SIG_LO_W-1:0]       in_sig_lo,
  input  logic [XTR_W-1:0]          in_extra,
  input  logic [1:0]                in_rmode,
  input  logic                      in_tiny_before,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_F_W+SIG_HI_W+SIG_LO_W-1:0] out_word,
  output logic                      out_ovf,
  output logic                      out_unf,
  output logic                      out_inx
);
  localparam int unsigned SIG_W  = SIG_HI_W + SIG_LO_W;
  localparam int unsigned WORD_W = EXP_F_W + SIG_W;

  logic [WORD_W-1:0] c_word;
  logic              c_ovf, c_unf, c_inx, take;

  fpq_round_core #(
    .SIG_W(SIG_W), .XTR_W(XTR_W), .EXP_IN_W(EXP_IN_W), .EXP_F_W(EXP_F_W)
  ) u_core (
    .sign(in_sign), .exp_in(in_exp), .sig({in_sig_hi, in_sig_lo}),
    .extra(in_extra), .mode(rmode_e'(in_rmode)), .tiny_before(in_tiny_before),
    .word(c_word), .ovf(c_ovf), .unf(c_unf), .inx(c_inx)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_inx   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= c_word;
      out_ovf   <= c_ovf;
      out_unf   <= c_unf;
      out_inx   <= c_inx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_inx));

  // R3
  ovf_sets_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_inx && !out_unf);

  // R6
  unf_sets_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_inx);

  // R4
  ovf_exp_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_word[WORD_W-2 -: EXP_F_W] >= EXP_F_W'((1 << EXP_F_W) - 2));

  // R10
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: tb/fpq_round_pack_bench.sv
`timescale 1ns/1ps
module fpq_round_pack_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ready;
  logic          in_sign = 1'b0;
  logic [31:0]   in_exp = '0;
  logic [48:0]   in_sig_hi = '0;
  logic [63:0]   in_sig_lo = '0, in_extra = '0;
  logic [1:0]    in_rmode = '0;
  logic          in_tiny_before = 1'b0;
  logic          out_valid, out_ready = 1'b1;
  logic [127:0]  out_word;
  logic          out_ovf, out_unf, out_inx;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fpq_round_pack u_fpq_round_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig_hi(in_sig_hi), .in_sig_lo(in_sig_lo),
    .in_extra(in_extra), .in_rmode(in_rmode), .in_tiny_before(in_tiny_before),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
  );

  localparam logic [48:0] H1   = 49'h1_0000_0000_0000;
  localparam logic [48:0] HALL = '1;
  localparam logic [63:0] LALL = '1;
  localparam logic [63:0] TIE  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] X1   = 64'h8000_0000_0000_0001;
  localparam logic [127:0] INF_P = 128'h7FFF_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] MAX_P = 128'h7FFE_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
  localparam int NV = 25;
  // {sign, exp, hi, lo, extra, mode, tiny_before, word, {ovf,unf,inx}}
  localparam logic [343:0] VEC [NV] = '{
    {1'b0, 32'h3FFE, H1, 64'd0, 64'd0, 2'b00, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 3'b000},
    {1'b0, 32'h3FFE, H1, 64'd0, TIE,   2'b00, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 3'b001},
    {1'b0, 32'h3FFE, H1, 64'd1, TIE,   2'b00, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0002, 3'b001},
    {1'b0, 32'h3FFE, H1, 64'd0, X1,    2'b00, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0001, 3'b001},
    {1'b0, 32'h3FFE, H1, 64'd5, LALL,  2'b01, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0005, 3'b001},
    {1'b0, 32'h3FFE, H1, 64'd5, 64'd1, 2'b11, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0006, 3'b001},
    {1'b1, 32'h3FFE, H1, 64'd5, 64'd1, 2'b11, 1'b0, 128'hBFFF_0000_0000_0000_0000_0000_0000_0005, 3'b001},
    {1'b1, 32'h3FFE, H1, 64'd5, 64'd1, 2'b10, 1'b0, 128'hBFFF_0000_0000_0000_0000_0000_0000_0006, 3'b001},
    {1'b0, 32'h3FFE, H1, 64'd5, 64'd1, 2'b10, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0005, 3'b001},
    {1'b0, 32'h3FFE, HALL, LALL, X1,   2'b00, 1'b0, 128'h4000_0000_0000_0000_0000_0000_0000_0000, 3'b001},
    {1'b0, 32'h7FFE, H1, 64'd0, 64'd0, 2'b00, 1'b0, INF_P, 3'b101},
    {1'b0, 32'h7FFE, H1, 64'd0, 64'd0, 2'b01, 1'b0, MAX_P, 3'b101},
    {1'b0, 32'h7FFD, HALL, LALL, TIE,  2'b00, 1'b0, INF_P, 3'b101},
    {1'b0, 32'h7FFD, HALL, LALL, 64'd0, 2'b00, 1'b0, MAX_P, 3'b000},
    {1'b1, 32'h8000, H1, 64'd0, 64'd0, 2'b10, 1'b0, 128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 3'b101},
    {1'b1, 32'h8000, H1, 64'd0, 64'd0, 2'b11, 1'b0, 128'hFFFE_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 3'b101},
    {1'b0, 32'hFFFF_FFFF, H1, 64'd0, 64'd0, 2'b00, 1'b0, 128'h0000_8000_0000_0000_0000_0000_0000_0000, 3'b000},
    {1'b0, 32'hFFFF_FFFF, H1, 64'd1, 64'd0, 2'b00, 1'b0, 128'h0000_8000_0000_0000_0000_0000_0000_0000, 3'b011},
    {1'b0, 32'hFFFF_FFFF, HALL, LALL, TIE, 2'b00, 1'b0, 128'h0001_0000_0000_0000_0000_0000_0000_0000, 3'b001},
    {1'b0, 32'hFFFF_FFFF, HALL, LALL, TIE, 2'b00, 1'b1, 128'h0001_0000_0000_0000_0000_0000_0000_0000, 3'b011},
    {1'b0, 32'hFFFF_FE0C, H1, 64'd0, 64'd0, 2'b00, 1'b0, 128'h0, 3'b011},
    {1'b0, 32'hFFFF_FE0C, H1, 64'd0, 64'd0, 2'b11, 1'b0, 128'h1, 3'b011},
    {1'b1, 32'hFFFF_FE0C, H1, 64'd0, 64'd0, 2'b10, 1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0001, 3'b011},
    {1'b0, 32'h1234, 49'd0, 64'd0, 64'd0, 2'b00, 1'b0, 128'h0, 3'b000},
    {1'b0, 32'h8000_0000, H1, 64'd0, 64'd0, 2'b00, 1'b0, 128'h0, 3'b011}
  };

  function automatic string tag_of(int i);
    case (i)
      0:  return "R9";
      1, 2, 3: return "R1 R7";
      4, 5, 6, 7, 8: return "R2 R7";
      9:  return "R9 R1";
      10, 11, 14, 15: return "R3 R4";
      12: return "R3 boundary";
      13: return "R3 R9 no-overflow";
      16: return "R5 exact";
      17: return "R5 R6";
      18, 19: return "R6 tininess";
      20, 21, 22, 24: return "R5 R6 R7 sticky";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [130:0] got, input logic [130:0] exp_v);
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp_v);
    end
  endtask

  task automatic load(input logic [343:0] v);
    in_sign        = v[343];
    in_exp         = v[342:311];
    in_sig_hi      = v[310:262];
    in_sig_lo      = v[261:198];
    in_extra       = v[197:134];
    in_rmode       = v[133:132];
    in_tiny_before = v[131];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset", {128'd0, out_valid, in_ready, 1'b0}, {128'd0, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      // R10: one-cycle latency, result present
      check(tag_of(i), {out_word, out_ovf, out_unf, out_inx},
            {VEC[i][130:3], VEC[i][2:0]});
      check("R10 valid", {130'd0, out_valid}, {130'd0, 1'b1});
    end
    @(negedge clk);

    // R10: back-pressure holds the result and blocks new input
    out_ready = 1'b0;
    load(VEC[0]);
    in_valid = 1'b1;
    @(negedge clk);
    load(VEC[2]);
    check("R10 stall ready", {129'd0, out_valid, in_ready}, {129'd0, 1'b1, 1'b0});
    @(negedge clk);
    check("R10 stall hold", {out_word, out_ovf, out_unf, out_inx}, {VEC[0][130:3], VEC[0][2:0]});
    out_ready = 1'b1;
    #1;
    check("R10 ready on drain", {130'd0, in_ready}, {130'd0, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next after stall", {out_word, out_ovf, out_unf, out_inx}, {VEC[2][130:3], VEC[2][2:0]});
    @(negedge clk);
    check("R10 drained", {130'd0, out_valid}, {130'd0, 1'b0});

    // R11: reset mid-stream clears valid
    load(VEC[3]);
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check("R11 reset clears", {130'd0, out_valid}, {130'd0, 1'b0});
    @(negedge clk);
    finish_run();
  end
endmodule